// File: doc/BRIEF.md
# Serial Controller Status and Command Registers

This block keeps the status word of a serial controller and updates it only through a write-only command word. The status word holds eight stored flags: an operating-mode enable, a master-select bit and six sticky error flags. A ninth bit, busy, is a live copy of an input from the datapath. Each stored flag has its own set bit and its own clear bit in the command word. Software never writes the status word directly, so it can change one flag without a read-modify-write of the others.

The datapath reports errors as one-cycle pulses on `err_evt`. The mode error is always captured. The other five errors are captured only while their bit in a separate error-mask register is 1. A captured error stays set until software clears it. The combined error interrupt stays high while any of the six error flags is set. A small register port gives the write and read access: the status word is read-only, the mask register can be read and written, and the command word is write-only.

Top module: `ssc_status_regs`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all stored flags and the error-mask register are 0. op_enable, master_sel and err_irq are then low.
- R2: The status word is read at address 0. Its bit positions are: 0 enable, 1 master select, 7 mode error, 8 transmit overflow, 9 receive overflow, 10 abort, 11 transmit underflow, 12 receive underflow. Bit 13 follows busy_in in the same cycle, and all other bits read 0.
- R3: A write of 1 to command bit 1 (address 2) sets enable, and a write of 1 to bit 0 clears it. The new value of enable drives op_enable after that clock edge. Enable 0 is configuration mode and enable 1 is operational mode.
- R4: A write of 1 to command bit 3 sets master select, and a write of 1 to bit 2 clears it. The new value drives master_sel after that clock edge.
- R5: The error flags have these command set bits: mode 7, transmit overflow 12, receive overflow 13, abort 14, transmit underflow 15, receive underflow 5. They have these clear bits: mode 6, transmit overflow 8, receive overflow 9, abort 10, transmit underflow 11, receive underflow 4.
- R6: err_evt bit 0 (mode error) always sets its flag. err_evt bits 1 to 5 (transmit overflow, receive overflow, abort, transmit underflow, receive underflow) set their flag only while mask-register bit 0 to 4 respectively is 1. The mask register is at address 1 and reads back in bits 4:0.
- R7: An error flag stays set after its event pulse ends and holds until a clear command for it.
- R8: err_irq is high exactly while at least one of the six error flags is set.
- R9: If a command write has both the set bit and the clear bit of one flag at 1, that flag keeps its previous value.
- R10: An event that arrives in the same cycle as a clear command for the same flag leaves the flag set.
- R11: Command bits written as 0 have no effect. Writes to the status address are ignored. The command address reads back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 status, 1 error mask, 2 command |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data for rd_addr (combinational) |
| err_evt | input | 6 | One-cycle error event pulses from the datapath |
| busy_in | input | 1 | Busy indication from the datapath |
| op_enable | output | 1 | Enable flag (1 = operational mode) |
| master_sel | output | 1 | Master-select flag |
| err_irq | output | 1 | Error interrupt, high while any error flag is set |

## Verification
A command write or an event pulse takes effect at the first rising edge at which it is present. Its effect shows on rd_data, op_enable, master_sel and err_irq right after that edge. The bench drives every stimulus on a falling edge and holds it for one full cycle. It then reads results on the next falling edge, one register stage after the stimulus. Reads are combinational, so a changed rd_addr or busy_in is sampled one time step later with no clock edge in between. The corner cases (set and clear written together, event colliding with clear, masked event, all-zero command) are each driven within a single cycle. Their results are read in that same post-edge window.

// File: rtl/ssc_status_pkg.sv
// Package: shared constants for the status/command register block.
// Assumes flag index order: 0 enable, 1 master select, 2 mode error,
// 3 tx overflow, 4 rx overflow, 5 abort, 6 tx underflow, 7 rx underflow.
package ssc_status_pkg;

    localparam int NFLAG    = 8;
    localparam int NERR_EVT = 6;
    localparam int NMASK    = NERR_EVT - 1;
    localparam int FIRST_ERR_FLAG = 2;

    localparam int ADDR_STATUS = 0;
    localparam int ADDR_MASK   = 1;
    localparam int ADDR_CMD    = 2;

    localparam int BUSY_POS = 13;

    // Bit position of each flag in the status word.
    localparam int STAT_POS [NFLAG] = '{0, 1, 7, 8, 9, 10, 11, 12};
    // Command word bit that sets each flag.
    localparam int SET_POS  [NFLAG] = '{1, 3, 7, 12, 13, 14, 15, 5};
    // Command word bit that clears each flag.
    localparam int CLR_POS  [NFLAG] = '{0, 2, 6, 8, 9, 10, 11, 4};

endpackage

// File: rtl/ssc_cmd_decode.sv
// Module: ssc_cmd_decode
// Turns a command-word write into per-flag set and clear strobes.
// Assumes DATA_W covers every command bit position listed in the package.
module ssc_cmd_decode
    import ssc_status_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                wr_stb,
    input  logic [DATA_W-1:0]   cmd,
    output logic [NFLAG-1:0]    set_o,
    output logic [NFLAG-1:0]    clr_o
);

    // One set/clear strobe pair per flag, selected by the package map.
    for (genvar i = 0; i < NFLAG; i++) begin : g_dec
        assign set_o[i] = wr_stb & cmd[SET_POS[i]];
        assign clr_o[i] = wr_stb & cmd[CLR_POS[i]];
    end

endmodule

// File: rtl/ssc_flag_cell.sv
// Module: ssc_flag_cell
// One sticky status bit. An event always sets it. A set or clear strobe alone
// changes it, and set and clear together leave it unchanged.
// Assumes synchronous active-low reset to 0.
module ssc_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic evt_i,
    output logic q_o
);

    // Flag update with event priority over any command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (evt_i)
            q_o <= 1'b1;
        else if (set_i && !clr_i)
            q_o <= 1'b1;
        else if (clr_i && !set_i)
            q_o <= 1'b0;
    end

endmodule

// File: rtl/ssc_status_regs.sv
// Module: ssc_status_regs (top)
// Status word, error-mask register and write-only command word of a serial
// controller. Error events are single-cycle pulses. Reads are combinational.
// Assumes DATA_W >= 16 and ADDR_W >= 2.
module ssc_status_regs
    import ssc_status_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NERR_EVT-1:0] err_evt,
    input  logic                busy_in,
    output logic                op_enable,
    output logic                master_sel,
    output logic                err_irq
);

    localparam int NERR = NFLAG - FIRST_ERR_FLAG;

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] evt_v;
    logic [NFLAG-1:0] flag_q;
    logic [NMASK-1:0] mask_q;
    logic             cmd_stb;
    logic             mask_stb;

    assign cmd_stb  = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));
    assign mask_stb = wr_en && (wr_addr == ADDR_W'(ADDR_MASK));

    // Error-mask register: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_stb)
            mask_q <= wr_data[NMASK-1:0];
    end

    ssc_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .wr_stb (cmd_stb),
        .cmd    (wr_data),
        .set_o  (set_v),
        .clr_o  (clr_v)
    );

    // Event routing: enable/master have no event, mode error is ungated,
    // the remaining errors are gated by their mask bit.
    for (genvar i = 0; i < NFLAG; i++) begin : g_evt
        if (i < FIRST_ERR_FLAG) begin : g_none
            assign evt_v[i] = 1'b0;
        end else if (i == FIRST_ERR_FLAG) begin : g_open
            assign evt_v[i] = err_evt[0];
        end else begin : g_gated
            assign evt_v[i] = err_evt[i-FIRST_ERR_FLAG] & mask_q[i-FIRST_ERR_FLAG-1];
        end
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        ssc_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .evt_i (evt_v[i]),
            .q_o   (flag_q[i])
        );
    end

    assign op_enable  = flag_q[0];
    assign master_sel = flag_q[1];
    assign err_irq    = |flag_q[NFLAG-1:NFLAG-NERR];

    // Read mux: pack the status word, show the mask, hide the command word.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADDR_STATUS)) begin
            for (int i = 0; i < NFLAG; i++)
                rd_data[STAT_POS[i]] = flag_q[i];
            rd_data[BUSY_POS] = busy_in;
        end else if (rd_addr == ADDR_W'(ADDR_MASK)) begin
            rd_data[NMASK-1:0] = mask_q;
        end
    end

endmodule

// File: rtl/ssc_status_checker.sv
// Module: ssc_status_checker
// Property checks on the status/command register block, bound to the top.
// Assumes the flag index order and bit maps of ssc_status_pkg.
module ssc_status_checker
    import ssc_status_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic [NERR_EVT-1:0] err_evt,
    input logic [NFLAG-1:0]    flag_q,
    input logic [NMASK-1:0]    mask_q,
    input logic                err_irq
);

    logic cmd_wr;
    logic [NFLAG-1:0] hit;
    logic [NFLAG-1:0] set_w;
    logic [NFLAG-1:0] clr_w;
    logic all_err_clr;

    assign cmd_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CMD));

    // Checker's own view of which flags see a gated event.
    always_comb begin
        hit = '0;
        hit[2] = err_evt[0];
        for (int e = 1; e < NERR_EVT; e++)
            hit[e+2] = err_evt[e] && mask_q[e-1];
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_cmd
        assign set_w[i] = cmd_wr && wr_data[SET_POS[i]];
        assign clr_w[i] = cmd_wr && wr_data[CLR_POS[i]];
    end

    assign all_err_clr = (&clr_w[NFLAG-1:2]) && (set_w[NFLAG-1:2] == '0) && (hit == '0);

    // R1: reset clears flags and mask.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (flag_q == '0 && mask_q == '0));

    // R8: clearing every error with no event drops the interrupt.
    assert_irq_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        all_err_clr |=> !err_irq);

    // R8: a captured event raises the interrupt.
    assert_irq_on_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> err_irq);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag_chk
        // R7: a set flag holds unless its clear bit is written.
        assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_w[i]) |=> flag_q[i]);

        // R9: set and clear together keep the flag when no event hits.
        assert_set_clr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (set_w[i] && clr_w[i] && !hit[i]) |=> $stable(flag_q[i]));

        // R10: an event wins over a clear in the same cycle.
        assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flag_q[i]);
    end

    for (genvar e = 1; e < NERR_EVT; e++) begin : g_mask_chk
        // R6: a masked event does not set a clear flag.
        assert_masked_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q[e+2] && err_evt[e] && !mask_q[e-1] && !set_w[e+2]) |=> !flag_q[e+2]);
    end

endmodule

bind ssc_status_regs ssc_status_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .err_evt (err_evt),
    .flag_q  (flag_q),
    .mask_q  (mask_q),
    .err_irq (err_irq)
);

// File: tb/test_ssc_status_regs.sv
// Bench: directed scenarios for ssc_status_regs, one task per scenario.
module test_ssc_status_regs;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 2;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [5:0]    err_evt = '0;
    logic          busy_in = 1'b0;
    logic          op_enable;
    logic          master_sel;
    logic          err_irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssc_status_regs #(.ADDR_W(AW), .DATA_W(DW)) i_ssc_status_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .err_evt(err_evt), .busy_in(busy_in), .op_enable(op_enable),
        .master_sel(master_sel), .err_irq(err_irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one write for one cycle, starting and ending on a falling edge.
    task automatic write_reg(input int addr, input logic [DW-1:0] data);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_evt(input logic [5:0] ev);
        err_evt = ev;
        @(negedge clk);
        err_evt = '0;
    endtask

    task automatic read_reg(input int addr, output logic [DW-1:0] val);
        rd_addr = AW'(addr);
        #1 val = rd_data;
    endtask

    function automatic logic [DW-1:0] st(input logic [DW-1:0] v);
        return v;
    endfunction

    task automatic t_reset;
        logic [DW-1:0] v;
        read_reg(0, v); check("R1 status after reset", v, 16'h0000);
        read_reg(1, v); check("R1 mask after reset", v, 16'h0000);
        check("R1 irq/en/ms after reset", {13'd0, err_irq, op_enable, master_sel}, 16'h0000);
    endtask

    task automatic t_enable_master;
        logic [DW-1:0] v;
        write_reg(2, 16'h0002);
        read_reg(0, v); check("R3 enable set status", v, 16'h0001);
        check("R3 op_enable high", {15'd0, op_enable}, 16'h0001);
        write_reg(2, 16'h0001);
        read_reg(0, v); check("R3 enable cleared", v, 16'h0000);
        write_reg(2, 16'h0008);
        read_reg(0, v); check("R4 master set status", v, 16'h0002);
        check("R4 master_sel high", {15'd0, master_sel}, 16'h0001);
        write_reg(2, 16'h0004);
        read_reg(0, v); check("R4 master cleared", v, 16'h0000);
    endtask

    task automatic t_error_cmds;
        logic [DW-1:0] v;
        write_reg(2, 16'hF0A0);
        read_reg(0, v); check("R5 all error set bits", v, 16'h1F80);
        check("R8 irq with errors", {15'd0, err_irq}, 16'h0001);
        write_reg(2, 16'h0F50);
        read_reg(0, v); check("R5 all error clear bits", v, 16'h0000);
        check("R8 irq released", {15'd0, err_irq}, 16'h0000);
        write_reg(2, 16'h2000);
        read_reg(0, v); check("R2 rx overflow at bit 9", v, 16'h0200);
        write_reg(2, 16'h0200);
    endtask

    task automatic t_gating;
        logic [DW-1:0] v;
        pulse_evt(6'h3F);
        read_reg(0, v); check("R6 mask 0 captures only mode error", v, 16'h0080);
        write_reg(2, 16'h0040);
        write_reg(1, 16'h001F);
        read_reg(1, v); check("R6 mask readback", v, 16'h001F);
        pulse_evt(6'h10);
        read_reg(0, v); check("R6 tx underflow captured", v, 16'h0800);
        repeat (3) @(negedge clk);
        read_reg(0, v); check("R7 flag sticky", v, 16'h0800);
        check("R8 irq held", {15'd0, err_irq}, 16'h0001);
        write_reg(2, 16'h0800);
        read_reg(0, v); check("R7 cleared by command", v, 16'h0000);
        write_reg(1, 16'h0001);
        pulse_evt(6'h02);
        read_reg(0, v); check("R6 tx overflow with its mask bit", v, 16'h0100);
        pulse_evt(6'h04);
        read_reg(0, v); check("R6 rx overflow masked", v, 16'h0100);
        write_reg(2, 16'h0100);
        write_reg(1, 16'h0000);
    endtask

    task automatic t_set_clr_together;
        logic [DW-1:0] v;
        write_reg(2, 16'h4000);
        write_reg(2, 16'h4400);
        read_reg(0, v); check("R9 set+clear keeps 1", v, 16'h0400);
        write_reg(2, 16'h0003);
        read_reg(0, v); check("R9 set+clear keeps 0", v, 16'h0400);
    endtask

    task automatic t_evt_vs_clear;
        logic [DW-1:0] v;
        write_reg(1, 16'h0004);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0400; err_evt = 6'h08;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; err_evt = '0;
        read_reg(0, v); check("R10 event beats clear", v, 16'h0400);
        write_reg(1, 16'h0000);
    endtask

    task automatic t_no_effect;
        logic [DW-1:0] v;
        write_reg(2, 16'h0002);
        write_reg(2, 16'h0000);
        read_reg(0, v); check("R11 zero command no effect", v, 16'h0401);
        write_reg(0, 16'hFFFF);
        read_reg(0, v); check("R11 status write ignored", v, 16'h0401);
        read_reg(1, v); check("R11 status write leaves mask", v, 16'h0000);
        read_reg(2, v); check("R11 command reads zero", v, 16'h0000);
    endtask

    task automatic t_busy;
        logic [DW-1:0] v;
        busy_in = 1'b1;
        read_reg(0, v); check("R2 busy bit 13 live", v, 16'h2401);
        busy_in = 1'b0;
        read_reg(0, v); check("R2 busy bit drops", v, 16'h0401);
    endtask

    task automatic t_reset_again;
        logic [DW-1:0] v;
        write_reg(1, 16'h001F);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_reg(0, v); check("R1 reset clears flags", v, 16'h0000);
        read_reg(1, v); check("R1 reset clears mask", v, 16'h0000);
        check("R1 irq low after reset", {15'd0, err_irq}, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_master();
        t_error_cmds();
        t_gating();
        t_set_clr_together();
        t_evt_vs_clear();
        t_no_effect();
        t_busy();
        t_reset_again();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule